// File: doc/BRIEF.md
# Multi-Lane Vector Add Unit

This block holds a vector register file and executes one integer vector-add command at a time. A command names two source registers and one destination register. The unit adds the sources element by element, modulo 2^64, and writes the sums into the destination. The elements are striped across four parallel lanes. Each lane has its own slice of the register storage and its own pipelined adder, so one group of four elements enters the lanes every cycle.

Two configuration registers control each command, and a scalar path writes them. The length register sets how many leading elements take part. The mask register holds one enable bit per element. The unit copies both registers when it accepts a command, so later writes to them affect only the next command. A debug port reads any element at any time and writes any element while the unit is idle. The debug port is also how element data is loaded before a command and checked after it.

The control is a four-state machine:
- `ST_IDLE` waits for a start strobe that carries the add opcode. On acceptance, transition *accept* leads to `ST_ISSUE`, or to `ST_DRAIN` when the length is zero.
- `ST_ISSUE` sends one element group per cycle, in increasing group order. Transition *last group* moves to `ST_DRAIN`.
- `ST_DRAIN` waits the adder depth plus one cycle while results retire. Transition *drained* moves to `ST_FINISH`.
- `ST_FINISH` raises the done pulse for one cycle. Transition *release* returns to `ST_IDLE`.

Top module: `vadd_unit`

## Requirements
- R1: After reset, busy and done are low, the length register holds 64 and every mask bit is set.
- R2: A start strobe accepted with opcode 2'b01 sets destination element i to (source1[i] + source2[i]) mod 2^64, for every i below the length whose mask bit is set.
- R3: Element i is handled by lane i mod 4, so G = ceil(length/4) groups are issued one per cycle. Done is high for exactly one cycle, in the cycle after the (G+3)-th rising edge that follows the accepting edge.
- R4: Destination elements at index length or above keep their value, including the unused lanes of a partial final group.
- R5: Mask bit i (bit i of the mask word) belongs to element i. An element whose mask bit is clear keeps its old destination value.
- R6: A length of zero writes no element and raises done in the cycle after the 3rd rising edge that follows the accepting edge.
- R7: Busy is high from the cycle after an accepting edge through the done cycle, and low in the cycle after done. A start strobe while busy is ignored.
- R8: When the destination equals one or both sources, every result uses the source values from before the command.
- R9: A length write above 64 saturates to 64. Length and mask writes made while a command runs take effect only from the next command.
- R10: A start strobe with any opcode other than 2'b01 is ignored: busy stays low and no element changes.
- R11: The debug read returns the addressed element combinationally. A debug write lands only while busy is low and is dropped while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Command start strobe |
| cmd_op | input | 2 | Command opcode, 2'b01 = vector add |
| cmd_vd | input | 3 | Destination register index |
| cmd_vs1 | input | 3 | First source register index |
| cmd_vs2 | input | 3 | Second source register index |
| busy | output | 1 | A command is in flight |
| done | output | 1 | One-cycle completion pulse |
| cfg_len_we | input | 1 | Length register write strobe |
| cfg_len | input | 7 | Length write value, saturated to 64 |
| cfg_mask_we | input | 1 | Mask register write strobe |
| cfg_mask | input | 64 | Mask write value, bit i for element i |
| dbg_we | input | 1 | Debug element write strobe, honoured only while idle |
| dbg_reg | input | 3 | Debug register index |
| dbg_idx | input | 6 | Debug element index |
| dbg_wdata | input | 64 | Debug write data |
| dbg_rdata | output | 64 | Debug read data for the addressed element |

## Verification
The add is tried with a full-length, fully enabled command whose operands include a carry out of bit 63, which shows that the sum wraps. It is then tried with a length of 10, which ends in a partial group and shows that the spare lanes are gated. A sparse mask pattern shows that per-element enables are kept apart from the length bound. A zero length separates the pure pipeline delay from the issue time.

In-place commands with the destination equal to one source, and then to both, show that reads come ahead of writes. During a running command, a second start strobe, configuration writes and a debug write show that the running command uses its snapshot and that the foreign register stays untouched. A follow-up command and an over-range length show when the new configuration takes effect. An unknown opcode shows that decoding rejects it.

// File: rtl/vadd_pkg.sv
package vadd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_FINISH
    } vadd_state_e;

    localparam logic [1:0] OP_VADD = 2'b01;

endpackage

// File: rtl/vadd_lane_bank.sv
// One lane's slice of the vector register file: row r of register v holds
// element r*LANES + lane. Two operand reads, one debug read, one write.
module vadd_lane_bank #(
    parameter int EW   = 64,
    parameter int NREG = 8,
    parameter int ROWS = 16
) (
    input  logic                    clk,
    input  logic [$clog2(NREG)-1:0] ra_reg,
    input  logic [$clog2(NREG)-1:0] rb_reg,
    input  logic [$clog2(ROWS)-1:0] r_row,
    output logic [EW-1:0]           ra_data,
    output logic [EW-1:0]           rb_data,
    input  logic [$clog2(NREG)-1:0] d_reg,
    input  logic [$clog2(ROWS)-1:0] d_row,
    output logic [EW-1:0]           d_data,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] w_reg,
    input  logic [$clog2(ROWS)-1:0] w_row,
    input  logic [EW-1:0]           w_data
);
    localparam int DEPTH = NREG * ROWS;

    logic [EW-1:0] mem [DEPTH];

    assign ra_data = mem[{ra_reg, r_row}];
    assign rb_data = mem[{rb_reg, r_row}];
    assign d_data  = mem[{d_reg, d_row}];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[{w_reg, w_row}] <= w_data;
        end
    end

endmodule

// File: rtl/vadd_lane_add.sv
// Lane adder: the sum is formed at entry and carried with its write address
// through LAT register stages; the write-back happens on the following edge.
module vadd_lane_add #(
    parameter int EW   = 64,
    parameter int RW   = 3,
    parameter int ROWW = 4,
    parameter int LAT  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_we,
    input  logic [RW-1:0]   in_vd,
    input  logic [ROWW-1:0] in_row,
    input  logic [EW-1:0]   in_a,
    input  logic [EW-1:0]   in_b,
    output logic            out_we,
    output logic [RW-1:0]   out_vd,
    output logic [ROWW-1:0] out_row,
    output logic [EW-1:0]   out_sum
);
    logic [LAT-1:0]  we_q;
    logic [RW-1:0]   vd_q  [LAT];
    logic [ROWW-1:0] row_q [LAT];
    logic [EW-1:0]   sum_q [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q <= '0;
        end else begin
            we_q[0] <= in_we;
            for (int s = 1; s < LAT; s++) begin
                we_q[s] <= we_q[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        vd_q[0]  <= in_vd;
        row_q[0] <= in_row;
        sum_q[0] <= in_a + in_b;
        for (int s = 1; s < LAT; s++) begin
            vd_q[s]  <= vd_q[s-1];
            row_q[s] <= row_q[s-1];
            sum_q[s] <= sum_q[s-1];
        end
    end

    assign out_we  = we_q[LAT-1];
    assign out_vd  = vd_q[LAT-1];
    assign out_row = row_q[LAT-1];
    assign out_sum = sum_q[LAT-1];

endmodule

// File: rtl/vadd_seq.sv
// Command sequencer: configuration registers, command snapshot, group
// counter and the IDLE / ISSUE / DRAIN / FINISH state machine.
module vadd_seq
    import vadd_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int NELEM = 64,
    parameter int LANES = 4,
    parameter int LAT   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cmd_start,
    input  logic [1:0]                        cmd_op,
    input  logic [$clog2(NREG)-1:0]           cmd_vd,
    input  logic [$clog2(NREG)-1:0]           cmd_vs1,
    input  logic [$clog2(NREG)-1:0]           cmd_vs2,
    input  logic                              cfg_len_we,
    input  logic [$clog2(NELEM+1)-1:0]        cfg_len,
    input  logic                              cfg_mask_we,
    input  logic [NELEM-1:0]                  cfg_mask,
    output logic                              busy,
    output logic                              done,
    output logic [$clog2(NREG)-1:0]           iss_vd,
    output logic [$clog2(NREG)-1:0]           iss_vs1,
    output logic [$clog2(NREG)-1:0]           iss_vs2,
    output logic [$clog2(NELEM/LANES)-1:0]    iss_row,
    output logic [LANES-1:0]                  iss_wen
);
    localparam int RW   = $clog2(NREG);
    localparam int LW   = $clog2(NELEM + 1);
    localparam int IW   = $clog2(NELEM);
    localparam int ROWW = $clog2(NELEM / LANES);
    localparam int LSEL = $clog2(LANES);
    localparam int DW   = $clog2(LAT + 1) + 1;

    vadd_state_e     state_q, state_d;
    logic [LW-1:0]   len_q, run_len_q;
    logic [NELEM-1:0] mask_q, run_mask_q;
    logic [RW-1:0]   vd_q, vs1_q, vs2_q;
    logic [ROWW-1:0] row_q, last_row;
    logic [DW-1:0]   drain_q;
    logic [LANES-1:0] lane_ok;
    logic            accept;

    assign accept   = (state_q == ST_IDLE) && cmd_start && (cmd_op == OP_VADD);
    assign last_row = ROWW'((run_len_q - LW'(1)) >> LSEL);

    // per-lane element index of the current group and its write permission
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [IW-1:0] elem;
        assign elem       = {row_q, LSEL'(l)};
        assign lane_ok[l] = ({1'b0, elem} < run_len_q) && run_mask_q[elem];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept, last group, drained, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (len_q == '0) ? ST_DRAIN : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (row_q == last_row) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (drain_q == DW'(LAT)) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = 1'b1;
        done    = 1'b0;
        iss_wen = '0;
        unique case (state_q)
            ST_IDLE:   busy    = 1'b0;
            ST_ISSUE:  iss_wen = lane_ok;
            ST_DRAIN:  ;
            ST_FINISH: done    = 1'b1;
            default:   busy    = 1'b0;
        endcase
    end

    assign iss_vd  = vd_q;
    assign iss_vs1 = vs1_q;
    assign iss_vs2 = vs2_q;
    assign iss_row = row_q;

    // configuration, command snapshot and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q      <= LW'(NELEM);
            mask_q     <= '1;
            run_len_q  <= '0;
            run_mask_q <= '0;
            vd_q       <= '0;
            vs1_q      <= '0;
            vs2_q      <= '0;
            row_q      <= '0;
            drain_q    <= '0;
        end else begin
            if (cfg_len_we) begin
                len_q <= (cfg_len > LW'(NELEM)) ? LW'(NELEM) : cfg_len;
            end
            if (cfg_mask_we) begin
                mask_q <= cfg_mask;
            end
            if (accept) begin
                run_len_q  <= len_q;
                run_mask_q <= mask_q;
                vd_q       <= cmd_vd;
                vs1_q      <= cmd_vs1;
                vs2_q      <= cmd_vs2;
                row_q      <= '0;
            end else if (state_q == ST_ISSUE) begin
                row_q <= row_q + ROWW'(1);
            end
            drain_q <= (state_q == ST_DRAIN) ? drain_q + DW'(1) : '0;
        end
    end

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start) |=> ($stable(vd_q) && $stable(run_len_q) && $stable(run_mask_q)));

    p_len_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q <= LW'(NELEM)) && (run_len_q <= LW'(NELEM)));

    p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start && (cmd_op != OP_VADD)) |=> !busy);

endmodule

// File: rtl/vadd_unit.sv
// Multi-lane vector add unit: sequencer plus LANES bank/adder pairs.
module vadd_unit #(
    parameter int NREG  = 8,
    parameter int NELEM = 64,
    parameter int EW    = 64,
    parameter int LANES = 4,
    parameter int LAT   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_start,
    input  logic [1:0]                 cmd_op,
    input  logic [$clog2(NREG)-1:0]    cmd_vd,
    input  logic [$clog2(NREG)-1:0]    cmd_vs1,
    input  logic [$clog2(NREG)-1:0]    cmd_vs2,
    output logic                       busy,
    output logic                       done,
    input  logic                       cfg_len_we,
    input  logic [$clog2(NELEM+1)-1:0] cfg_len,
    input  logic                       cfg_mask_we,
    input  logic [NELEM-1:0]           cfg_mask,
    input  logic                       dbg_we,
    input  logic [$clog2(NREG)-1:0]    dbg_reg,
    input  logic [$clog2(NELEM)-1:0]   dbg_idx,
    input  logic [EW-1:0]              dbg_wdata,
    output logic [EW-1:0]              dbg_rdata
);
    localparam int RW   = $clog2(NREG);
    localparam int IW   = $clog2(NELEM);
    localparam int ROWS = NELEM / LANES;
    localparam int ROWW = $clog2(ROWS);
    localparam int LSEL = $clog2(LANES);

    logic [RW-1:0]    iss_vd, iss_vs1, iss_vs2;
    logic [ROWW-1:0]  iss_row;
    logic [LANES-1:0] iss_wen;
    logic [LANES-1:0] add_we;
    logic [EW-1:0]    bank_dbg [LANES];
    logic [LSEL-1:0]  dbg_lane;
    logic [ROWW-1:0]  dbg_row;
    logic             dbg_ok;

    assign dbg_lane = dbg_idx[LSEL-1:0];
    assign dbg_row  = dbg_idx[IW-1:LSEL];
    assign dbg_ok   = dbg_we && !busy;

    vadd_seq #(
        .NREG (NREG),
        .NELEM(NELEM),
        .LANES(LANES),
        .LAT  (LAT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_op     (cmd_op),
        .cmd_vd     (cmd_vd),
        .cmd_vs1    (cmd_vs1),
        .cmd_vs2    (cmd_vs2),
        .cfg_len_we (cfg_len_we),
        .cfg_len    (cfg_len),
        .cfg_mask_we(cfg_mask_we),
        .cfg_mask   (cfg_mask),
        .busy       (busy),
        .done       (done),
        .iss_vd     (iss_vd),
        .iss_vs1    (iss_vs1),
        .iss_vs2    (iss_vs2),
        .iss_row    (iss_row),
        .iss_wen    (iss_wen)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [EW-1:0]   ra, rb, dd, sum;
        logic            owe, dwe;
        logic [RW-1:0]   ovd;
        logic [ROWW-1:0] orow;

        // adder write-back has the port; debug writes only reach it when idle
        assign dwe = dbg_ok && (dbg_lane == LSEL'(l));

        vadd_lane_bank #(
            .EW  (EW),
            .NREG(NREG),
            .ROWS(ROWS)
        ) u_bank (
            .clk    (clk),
            .ra_reg (iss_vs1),
            .rb_reg (iss_vs2),
            .r_row  (iss_row),
            .ra_data(ra),
            .rb_data(rb),
            .d_reg  (dbg_reg),
            .d_row  (dbg_row),
            .d_data (dd),
            .we     (owe | dwe),
            .w_reg  (owe ? ovd : dbg_reg),
            .w_row  (owe ? orow : dbg_row),
            .w_data (owe ? sum : dbg_wdata)
        );

        vadd_lane_add #(
            .EW  (EW),
            .RW  (RW),
            .ROWW(ROWW),
            .LAT (LAT)
        ) u_add (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_we  (iss_wen[l]),
            .in_vd  (iss_vd),
            .in_row (iss_row),
            .in_a   (ra),
            .in_b   (rb),
            .out_we (owe),
            .out_vd (ovd),
            .out_row(orow),
            .out_sum(sum)
        );

        assign add_we[l]   = owe;
        assign bank_dbg[l] = dd;
    end

    assign dbg_rdata = bank_dbg[dbg_lane];

    p_no_pipe_write_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (add_we == '0));

    p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_idle_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: tb/test_vadd_unit.sv
`timescale 1ns/1ps
module test_vadd_unit;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_vd = '0, cmd_vs1 = '0, cmd_vs2 = '0;
    logic        busy, done;
    logic        cfg_len_we = 1'b0;
    logic [6:0]  cfg_len = '0;
    logic        cfg_mask_we = 1'b0;
    logic [63:0] cfg_mask = '0;
    logic        dbg_we = 1'b0;
    logic [2:0]  dbg_reg = '0;
    logic [5:0]  dbg_idx = '0;
    logic [63:0] dbg_wdata = '0;
    logic [63:0] dbg_rdata;

    always #2 clk = ~clk;

    vadd_unit i_vadd_unit (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_vd(cmd_vd),
        .cmd_vs1(cmd_vs1), .cmd_vs2(cmd_vs2),
        .busy(busy), .done(done),
        .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
        .cfg_mask_we(cfg_mask_we), .cfg_mask(cfg_mask),
        .dbg_we(dbg_we), .dbg_reg(dbg_reg), .dbg_idx(dbg_idx),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [63:0] mdl [8][64];
    int          m_len = 64;
    logic [63:0] m_mask = '1;

    int          q_reg[$];
    int          q_idx[$];
    logic [63:0] q_val[$];
    string       q_tag[$];
    bit          mon_busy = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor: reads each expected element back through the debug port
    initial begin
        forever begin
            @(negedge clk);
            while (q_reg.size() > 0) begin
                int r, i;
                logic [63:0] v;
                string t;
                mon_busy = 1;
                r = q_reg.pop_front();
                i = q_idx.pop_front();
                v = q_val.pop_front();
                t = q_tag.pop_front();
                dbg_reg = r[2:0];
                dbg_idx = i[5:0];
                #1;
                check(dbg_rdata == v, t, dbg_rdata, v, $sformatf("reg %0d elem %0d", r, i));
                mon_busy = 0;
            end
        end
    end

    task automatic push_one(input int r, input int i, input string tag);
        q_reg.push_back(r);
        q_idx.push_back(i);
        q_val.push_back(mdl[r][i]);
        q_tag.push_back(tag);
    endtask

    task automatic push_reg(input int r, input string tag);
        for (int i = 0; i < 64; i++) push_one(r, i, tag);
        do @(negedge clk); while (q_reg.size() != 0 || mon_busy);
    endtask

    task automatic dbg_write(input int r, input int i, input logic [63:0] v);
        @(negedge clk);
        dbg_we = 1; dbg_reg = r[2:0]; dbg_idx = i[5:0]; dbg_wdata = v;
        @(negedge clk);
        dbg_we = 0;
        mdl[r][i] = v;
    endtask

    task automatic set_len(input int v);
        @(negedge clk);
        cfg_len_we = 1; cfg_len = v[6:0];
        @(negedge clk);
        cfg_len_we = 0;
        m_len = (v > 64) ? 64 : v;
    endtask

    task automatic set_mask(input logic [63:0] m);
        @(negedge clk);
        cfg_mask_we = 1; cfg_mask = m;
        @(negedge clk);
        cfg_mask_we = 0;
        m_mask = m;
    endtask

    // driver: computes the expected destination, issues the command, times done
    task automatic run_vadd(input int vd, input int s1, input int s2,
                            input string tag, input string lat_tag, input bit interfere);
        logic [63:0] a [64];
        logic [63:0] b [64];
        int g, cnt, exp_cnt;
        for (int i = 0; i < 64; i++) begin
            a[i] = mdl[s1][i];
            b[i] = mdl[s2][i];
        end
        for (int i = 0; i < m_len; i++) begin
            if (m_mask[i]) mdl[vd][i] = a[i] + b[i];
        end
        g = (m_len + 3) / 4;
        exp_cnt = g + LAT + 2;
        @(negedge clk);
        cmd_start = 1; cmd_op = 2'b01;
        cmd_vd = vd[2:0]; cmd_vs1 = s1[2:0]; cmd_vs2 = s2[2:0];
        @(negedge clk);
        cmd_start = 0;
        cnt = 1;
        check(busy == 1'b1, "R7", 64'(busy), 64'd1, "busy after accept");
        while (!done && cnt < 400) begin
            if (interfere && cnt == 2) begin
                cmd_start = 1; cmd_vd = 3'd7;
                cfg_len_we = 1; cfg_len = 7'd5;
                cfg_mask_we = 1; cfg_mask = '0;
                dbg_we = 1; dbg_reg = vd[2:0]; dbg_idx = '0; dbg_wdata = 64'h5555_AAAA_5555_AAAA;
            end else begin
                cmd_start = 0; cfg_len_we = 0; cfg_mask_we = 0; dbg_we = 0;
            end
            @(negedge clk);
            cnt++;
        end
        cmd_start = 0; cfg_len_we = 0; cfg_mask_we = 0; dbg_we = 0;
        if (interfere) begin
            m_len = 5;
            m_mask = '0;
        end
        check(cnt == exp_cnt, lat_tag, 64'(cnt), 64'(exp_cnt), "done cycle after accept");
        @(negedge clk);
        check(!busy && !done, "R7", {62'd0, busy, done}, 64'd0, "busy/done after done");
        push_reg(vd, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < 64; i++) mdl[r][i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done, "R1", {62'd0, busy, done}, 64'd0, "busy/done in reset");
        rst_n = 1;
        @(negedge clk);
        check(!busy && !done, "R1", {62'd0, busy, done}, 64'd0, "busy/done after reset");

        // R11: preload through the debug port
        for (int i = 0; i < 64; i++) begin
            dbg_write(1, i, (i == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0123_4567_89AB_0000 + 64'(i) * 64'h1_0001);
            dbg_write(2, i, (i == 0) ? 64'd5 : 64'h0F0F_0000_0000_0000 + 64'(i * i));
            dbg_write(3, i, 64'(i) * 64'h1000_0000_0001);
        end
        for (int r = 4; r < 8; r++)
            for (int i = 0; i < 64; i++)
                dbg_write(r, i, 64'hDEAD_0000_0000_0000 + (64'(r) << 32) + 64'(i));
        push_reg(1, "R11");

        // R1/R2: reset length 64 and full mask, sum with wrap in element 0
        run_vadd(3, 1, 2, "R2", "R1", 0);
        // R4: length 10 ends in a partial group
        set_len(10);
        run_vadd(4, 1, 3, "R4", "R3", 0);
        // R5: sparse mask
        set_len(64);
        set_mask(64'hA5A5_0F0F_3C3C_9999);
        run_vadd(5, 2, 3, "R5", "R3", 0);
        // R6: zero length
        set_mask('1);
        set_len(0);
        run_vadd(6, 1, 2, "R6", "R6", 0);
        // R8: in place, one and both sources
        set_len(64);
        run_vadd(1, 1, 1, "R8", "R3", 0);
        run_vadd(2, 3, 2, "R8", "R3", 0);
        // R7: second start, config and debug writes during a command
        run_vadd(2, 2, 3, "R7", "R3", 1);
        push_reg(7, "R7");
        push_one(2, 0, "R11");
        do @(negedge clk); while (q_reg.size() != 0 || mon_busy);
        // R9: new length 5 and empty mask apply to the next command
        run_vadd(4, 1, 2, "R9", "R9", 0);
        // R9: over-range length saturates
        set_mask('1);
        set_len(100);
        run_vadd(6, 2, 3, "R9", "R9", 0);
        // R10: unknown opcode ignored
        @(negedge clk);
        cmd_start = 1; cmd_op = 2'b10; cmd_vd = 3'd7; cmd_vs1 = 3'd1; cmd_vs2 = 3'd2;
        @(negedge clk);
        cmd_start = 0;
        for (int k = 0; k < 6; k++) begin
            check(!busy && !done, "R10", {62'd0, busy, done}, 64'd0, "idle after bad opcode");
            @(negedge clk);
        end
        push_reg(7, "R10");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule